// File: doc/BRIEF.md
# Nonvolatile Memory Command Sequence Detector

This block sits beside an asynchronous SRAM-style port and watches its accesses without taking part in them. Software raises a nonvolatile operation by reading six addresses in a fixed order, with no write in between. Five unlock addresses must come first. The sixth address then picks one of four operations: turn automatic saving on power loss off, turn it on, copy the array into the nonvolatile cells now, or copy the nonvolatile cells back into the array. Ordinary reads at any address are served by the array as usual. The detector never stalls the bus.

Each access is counted once. The interface logic raises `acc_stb` for one clock per access, after it has synchronized the strobes. When a series completes, the detector issues a command to the store and recall engines as a one-clock pulse on `cmd_valid`, with `cmd_code` alongside. This output has no ready signal and no back-pressure: the engines must accept the pulse in the cycle it appears. For the save and restore commands, the detector also asks the data-bus drivers to float the outputs during the sixth read (`dout_hiz`).

Top module: `nvcmd_seq_detect`

## Requirements
- R1: A read is counted only when `acc_stb` is high with `cs_n`=0, `we_n`=1 and `oe_n`=0. The five counted reads 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order, arm the detector. A sixth counted read at a command address then issues a command.
- R2: The sixth-read addresses map to `cmd_code` values as follows: 0x03F8 → 0 (autosave off), 0x07F0 → 1 (autosave on), 0x0FC0 → 2 (store), 0x0C63 → 3 (recall). `cmd_valid` is high for exactly the one clock after the strobe edge that captured the sixth read.
- R3: A strobe with `cs_n`=1 is ignored. The progress of the series is unchanged and no command results.
- R4: Only `addr[13:0]` is compared. Bit 14 may take any value on every read of a series.
- R5: A strobed write (`cs_n`=0, `we_n`=0) cancels a series in progress.
- R6: A counted read that does not match the next expected unlock address cancels the series. If that address is 0x0E38, it is taken as the first step of a new series.
- R7: A strobed access with `cs_n`=0, `we_n`=1 and `oe_n`=1 is neither a read nor a write, and it cancels the series.
- R8: `dout_hiz` is high during the sixth read of a store or recall command. It rises as soon as that read is presented and stays high until `cs_n` returns to 1. It is never high for the autosave commands, for normal reads, or while `cs_n`=1.
- R9: A synchronous active-low `rst_n` returns the detector to idle with `cmd_valid` and `dout_hiz` low. A series cut by reset must start again from its first address.
- R10: A sixth counted read at an address that is not a command address issues nothing and cancels the series. The 0x0E38 restart of R6 applies here too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_stb | input | 1 | One-clock pulse per bus access, qualifying the strobes and address |
| cs_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (15) | Access address |
| cmd_valid | output | 1 | One-clock command pulse, no back-pressure |
| cmd_code | output | 2 | Command code, meaningful while `cmd_valid` is high |
| dout_hiz | output | 1 | Request to float the data outputs |

## Verification
The bench builds the detector with its default 15-bit address, which keeps bit 14 in play as the ignored upper bit of R4. The unlock length is fixed at five, so the bench can run every command code, and also restarts and aborts at each point it drives. Accesses take several clocks, so the bench sees the float request both before and after the capturing strobe and then after deselect. That shows the early assertion and the hold behaviour of R8.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
  localparam int KEY_W    = 14;
  localparam int UNLOCK_N = 5;
  localparam int CMD_N    = 4;

  typedef enum logic [1:0] {
    CMD_AS_OFF = 2'd0,
    CMD_AS_ON  = 2'd1,
    CMD_STORE  = 2'd2,
    CMD_RECALL = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_OTHER = 2'd3
  } acc_e;

  function automatic logic [KEY_W-1:0] unlock_key(input int idx);
    case (idx)
      0:       unlock_key = 14'h0E38;
      1:       unlock_key = 14'h31C7;
      2:       unlock_key = 14'h03E0;
      3:       unlock_key = 14'h3C1F;
      4:       unlock_key = 14'h303F;
      default: unlock_key = '0;
    endcase
  endfunction

  function automatic logic [KEY_W-1:0] cmd_key(input int idx);
    case (idx)
      0:       cmd_key = 14'h03F8;
      1:       cmd_key = 14'h07F0;
      2:       cmd_key = 14'h0FC0;
      3:       cmd_key = 14'h0C63;
      default: cmd_key = '0;
    endcase
  endfunction
endpackage

// File: rtl/nvcmd_acc_decode.sv
module nvcmd_acc_decode
  import nvcmd_pkg::*;
(
  input  logic acc_stb,
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  output acc_e kind,
  output logic rd_level
);
  // rd_level: strobe-independent read condition, used for the float request
  assign rd_level = !cs_n && we_n && !oe_n;

  always_comb begin
    if (!acc_stb || cs_n) kind = ACC_IDLE;
    else if (!we_n)       kind = ACC_WRITE;
    else if (!oe_n)       kind = ACC_READ;
    else                  kind = ACC_OTHER;
  end
endmodule

// File: rtl/nvcmd_addr_match.sv
module nvcmd_addr_match
  import nvcmd_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [KEY_W-1:0]  key,
  input  logic [STEP_W-1:0] step,
  output logic              seq_hit,
  output logic              restart_hit,
  output logic              cmd_hit,
  output logic [1:0]        cmd_code,
  output logic              float_sel
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(UNLOCK_N);

  logic [UNLOCK_N-1:0] ukey_eq;
  logic [CMD_N-1:0]    ckey_eq;

  genvar gi;
  generate
    for (gi = 0; gi < UNLOCK_N; gi++) begin : g_ukey
      assign ukey_eq[gi] = (key == unlock_key(gi));
    end
    for (gi = 0; gi < CMD_N; gi++) begin : g_ckey
      assign ckey_eq[gi] = (key == cmd_key(gi));
    end
  endgenerate

  assign restart_hit = ukey_eq[0];

  always_comb begin
    seq_hit = 1'b0;
    for (int i = 0; i < UNLOCK_N; i++)
      if (step == i[STEP_W-1:0]) seq_hit = ukey_eq[i];
  end

  always_comb begin
    cmd_code = 2'd0;
    for (int c = 0; c < CMD_N; c++)
      if (ckey_eq[c]) cmd_code = c[1:0];
  end

  assign cmd_hit   = (step == LAST_STEP) && (|ckey_eq);
  assign float_sel = (step == LAST_STEP) &&
                     (ckey_eq[int'(CMD_STORE)] || ckey_eq[int'(CMD_RECALL)]);
endmodule

// File: rtl/nvcmd_seq_fsm.sv
module nvcmd_seq_fsm
  import nvcmd_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  acc_e              kind,
  input  logic              rd_level,
  input  logic              seq_hit,
  input  logic              restart_hit,
  input  logic              cmd_hit,
  input  logic [1:0]        hit_code,
  input  logic              float_sel,
  output logic [STEP_W-1:0] step_q,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic              dout_hiz
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(UNLOCK_N);
  localparam logic [STEP_W-1:0] ONE       = STEP_W'(1);

  logic              hiz_hold;
  logic [STEP_W-1:0] fallback;

  assign fallback = restart_hit ? ONE : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q    <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= 2'd0;
      hiz_hold  <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (cs_n) hiz_hold <= 1'b0;
      case (kind)
        ACC_READ: begin
          if (step_q == LAST_STEP) begin
            if (cmd_hit) begin
              cmd_valid <= 1'b1;
              cmd_code  <= hit_code;
              hiz_hold  <= float_sel;
              step_q    <= '0;
            end else begin
              step_q    <= fallback;
            end
          end else begin
            step_q <= seq_hit ? step_q + ONE : fallback;
          end
        end
        ACC_WRITE, ACC_OTHER: step_q <= '0;
        default: ;
      endcase
    end
  end

  // Early float as soon as the sixth store/recall read is presented,
  // held after capture until the chip is deselected.
  assign dout_hiz = (rd_level && float_sel) || (hiz_hold && !cs_n);
endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic              dout_hiz
);
  localparam int STEP_W = $clog2(UNLOCK_N + 1);

  acc_e              kind;
  logic              rd_level;
  logic              seq_hit, restart_hit, cmd_hit, float_sel;
  logic [1:0]        hit_code;
  logic [STEP_W-1:0] step_q;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^addr[ADDR_W-1:KEY_W];

  nvcmd_acc_decode u_dec (
    .acc_stb (acc_stb),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .kind    (kind),
    .rd_level(rd_level)
  );

  nvcmd_addr_match #(.STEP_W(STEP_W)) u_match (
    .key        (addr[KEY_W-1:0]),
    .step       (step_q),
    .seq_hit    (seq_hit),
    .restart_hit(restart_hit),
    .cmd_hit    (cmd_hit),
    .cmd_code   (hit_code),
    .float_sel  (float_sel)
  );

  nvcmd_seq_fsm #(.STEP_W(STEP_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .kind       (kind),
    .rd_level   (rd_level),
    .seq_hit    (seq_hit),
    .restart_hit(restart_hit),
    .cmd_hit    (cmd_hit),
    .hit_code   (hit_code),
    .float_sel  (float_sel),
    .step_q     (step_q),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .dout_hiz   (dout_hiz)
  );
endmodule

// File: rtl/nvcmd_seq_detect_chk.sv
module nvcmd_seq_detect_chk #(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_stb,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              cmd_valid,
  input logic              dout_hiz,
  input logic [STEP_W-1:0] step_q
);
  a_r2_one_clock_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r1_cmd_from_sixth_read: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(acc_stb && !cs_n && we_n && !oe_n && step_q == STEP_W'(5)));

  a_r3_deselect_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && cs_n) |=> ($stable(step_q) && !cmd_valid));

  a_r5_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !cs_n && !we_n) |=> (step_q == '0 && !cmd_valid));

  a_r7_other_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !cs_n && we_n && oe_n) |=> (step_q == '0 && !cmd_valid));

  a_r8_float_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    dout_hiz |-> !cs_n);

  a_r9_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(5));
endmodule

bind nvcmd_seq_detect nvcmd_seq_detect_chk #(.STEP_W(STEP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_stb  (acc_stb),
  .cs_n     (cs_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .cmd_valid(cmd_valid),
  .dout_hiz (dout_hiz),
  .step_q   (step_q)
);

// File: tb/nvcmd_seq_detect_bench.sv
module nvcmd_seq_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_stb = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [14:0] addr = '0;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic        dout_hiz;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // observations of the last access
  logic o_hiz_pre, o_valid, o_hiz_post, o_valid_late, o_hiz_desel;
  logic [1:0] o_code;

  always #2.5 clk = ~clk;

  nvcmd_seq_detect u_nvcmd_seq_detect (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .dout_hiz(dout_hiz)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One access spanning three clocks: present+strobe, hold, deselect.
  task automatic access(input logic c, input logic w, input logic o, input logic [14:0] a);
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; addr = a; acc_stb = 1'b1;
    #1 o_hiz_pre = dout_hiz;
    @(negedge clk);
    acc_stb = 1'b0;
    o_valid = cmd_valid; o_code = cmd_code; o_hiz_post = dout_hiz;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    o_valid_late = cmd_valid;
    #1 o_hiz_desel = dout_hiz;
  endtask

  task automatic rd(input logic [14:0] a);
    access(1'b0, 1'b1, 1'b0, a);
  endtask

  task automatic unlock(input logic hi);
    rd({hi, 14'h0E38}); rd({hi, 14'h31C7}); rd({hi, 14'h03E0});
    rd({hi, 14'h3C1F}); rd({hi, 14'h303F});
  endtask

  task automatic t_reset_state();
    chk("R9 reset cmd_valid", int'(cmd_valid), 0);
    chk("R9 reset dout_hiz", int'(dout_hiz), 0);
  endtask

  task automatic t_all_commands();
    logic [13:0] keys [4] = '{14'h03F8, 14'h07F0, 14'h0FC0, 14'h0C63};
    for (int c = 0; c < 4; c++) begin
      unlock(1'b0);
      rd({1'b0, keys[c]});
      chk("R1 command issued", int'(o_valid), 1);
      chk("R2 code", int'(o_code), c);
      chk("R2 single clock pulse", int'(o_valid_late), 0);
      chk("R8 early float", int'(o_hiz_pre), (c >= 2) ? 1 : 0);
      chk("R8 float held", int'(o_hiz_post), (c >= 2) ? 1 : 0);
      chk("R8 float released", int'(o_hiz_desel), 0);
    end
  endtask

  task automatic t_bit14();
    unlock(1'b1);
    rd({1'b1, 14'h0C63});
    chk("R4 bit14 ignored valid", int'(o_valid), 1);
    chk("R4 bit14 ignored code", int'(o_code), 3);
  endtask

  task automatic t_write_abort();
    rd(15'h0E38); rd(15'h31C7); rd(15'h03E0);
    access(1'b0, 1'b0, 1'b1, 15'h0000);
    rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0);
    chk("R5 write cancels", int'(o_valid), 0);
    chk("R5 no float after cancel", int'(o_hiz_pre), 0);
  endtask

  task automatic t_wrong_and_restart();
    rd(15'h0E38); rd(15'h31C7); rd(15'h1234);
    rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h03F8);
    chk("R6 wrong address cancels", int'(o_valid), 0);
    rd(15'h0E38); rd(15'h31C7); rd(15'h0E38); rd(15'h31C7);
    rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0);
    chk("R6 restart on first key", int'(o_valid), 1);
    chk("R6 restart code", int'(o_code), 2);
  endtask

  task automatic t_deselect_ignored();
    rd(15'h0E38); rd(15'h31C7);
    access(1'b1, 1'b1, 1'b0, 15'h5555);
    access(1'b1, 1'b0, 1'b0, 15'h0000);
    rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h07F0);
    chk("R3 deselected strobes ignored", int'(o_valid), 1);
    chk("R3 code", int'(o_code), 1);
    chk("R8 no float for autosave on", int'(o_hiz_post), 0);
  endtask

  task automatic t_other_abort();
    rd(15'h0E38); rd(15'h31C7); rd(15'h03E0); rd(15'h3C1F);
    access(1'b0, 1'b1, 1'b1, 15'h303F);
    rd(15'h303F); rd(15'h03F8);
    chk("R7 output-disabled access cancels", int'(o_valid), 0);
  endtask

  task automatic t_bad_sixth();
    unlock(1'b0);
    rd(15'h0E38);
    chk("R10 non-command sixth", int'(o_valid), 0);
    rd(15'h31C7); rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0C63);
    chk("R10 restart after bad sixth", int'(o_valid), 1);
    rd(15'h0FC0);
    chk("R8 plain read no float", int'(o_hiz_pre), 0);
    chk("R8 plain read no command", int'(o_valid), 0);
  endtask

  task automatic t_reset_mid();
    unlock(1'b0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(15'h0FC0);
    chk("R9 reset clears series", int'(o_valid), 0);
    chk("R9 reset no float", int'(o_hiz_pre), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_all_commands();
    t_bit14();
    t_write_abort();
    t_wrong_and_restart();
    t_deselect_ignored();
    t_other_abort();
    t_bad_sixth();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule